// File: doc/BRIEF.md
# Modem Status Change Detector

This block watches the four incoming modem handshake lines (clear-to-send, data-set-ready, ring indicator and carrier detect). Each line passes through a multi-flop synchroniser. The block then publishes an 8-bit status byte. The upper nibble of that byte gives the present level of each line. The lower nibble holds per-line change flags that stay set until software reads the status byte. Any set flag raises a modem-status interrupt request, but only while the matching interrupt-enable bit is high.

The block also owns the four modem-control outputs (data-terminal-ready, request-to-send, an auxiliary output and an interrupt-gate output), which are driven from a 5-bit control word. Bit 4 of that word selects a diagnostic loopback. In loopback the control bits stand in for the external lines, so firmware can exercise the whole detect path without a cable. During loopback all four outputs are forced inactive.

Top module: `mdm_status_top`

## Requirements
- R1: Status bit 0 sets when the clear-to-send level changes in either direction. Bit 1 does the same for data-set-ready, and bit 3 for carrier detect.
- R2: Status bits 4, 5, 6 and 7 show the present levels of clear-to-send, data-set-ready, ring indicator and carrier detect. An external line change reaches its level bit after two rising clock edges, and reaches its change flag one edge later.
- R3: `msIrq` is high exactly when `msIntEn` is high and at least one of status bits 0 to 3 is set.
- R4: A change flag stays set, whatever the lines do, until a status read occurs.
- R5: A cycle with `statusRead` high clears all four change flags at the next edge. A change detected in that same cycle leaves its own flag set.
- R6: Outside loopback, control bits 0, 1, 2 and 3 drive `dtrOut`, `rtsOut`, `auxOut` and `gateOut`. While control bit 4 is high, all four outputs are held at 0.
- R7: While control bit 4 is high, the clear-to-send level follows control bit 1, data-set-ready follows bit 0, ring indicator follows bit 2 and carrier detect follows bit 3. The external lines then have no effect on the status byte.
- R8: After reset the status byte reads 0. No change flag is raised while the first synchronised samples load the reference levels, even when lines are held high through reset.
- R9: Status bit 2 sets only on a trailing edge of the ring indicator (1 to 0). A rising ring indicator leaves it clear.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctsIn | input | 1 | External clear-to-send line (asynchronous) |
| dsrIn | input | 1 | External data-set-ready line (asynchronous) |
| riIn | input | 1 | External ring indicator line (asynchronous) |
| dcdIn | input | 1 | External carrier detect line (asynchronous) |
| ctrlBits | input | 5 | Modem control word: bit0 DTR, bit1 RTS, bit2 aux, bit3 interrupt gate, bit4 loopback |
| msIntEn | input | 1 | Modem-status interrupt enable |
| statusRead | input | 1 | One-cycle strobe marking a read of the status byte |
| statusByte | output | 8 | Change flags [3:0] and line levels [7:4] |
| msIrq | output | 1 | Modem-status interrupt request |
| dtrOut | output | 1 | Data-terminal-ready output |
| rtsOut | output | 1 | Request-to-send output |
| auxOut | output | 1 | Auxiliary output |
| gateOut | output | 1 | Interrupt-gate output |

## Verification
The clear-on-read and a fresh line change can fall in the same cycle. If the design handled them badly, the change would be lost. The bench provokes the collision in loopback, where a control write changes a level without synchroniser delay. It raises the data-set-ready source in exactly the cycle that carries the read strobe. The case is judged by requiring that, after that edge, only the data-set-ready flag remains set while the older flags have cleared.

// File: rtl/mdm_pkg.sv
package mdm_pkg;
  localparam int NUM_LINES = 4;

  // line index inside a level/flag nibble
  localparam int LN_CTS = 0;
  localparam int LN_DSR = 1;
  localparam int LN_RI  = 2;
  localparam int LN_DCD = 3;

  // control word bit positions
  localparam int CB_DTR  = 0;
  localparam int CB_RTS  = 1;
  localparam int CB_AUX  = 2;
  localparam int CB_GATE = 3;
  localparam int CB_LOOP = 4;
  localparam int CTRL_W  = 5;

  typedef struct packed {
    logic primed;    // reference levels hold a valid sample
    logic clrFlags;  // status byte is being read this cycle
  } mdm_strobe_t;
endpackage

// File: rtl/mdm_status_ctl.sv
module mdm_status_ctl
  import mdm_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        statusRead,
  output mdm_strobe_t strb
);
  // one extra cycle so the reference register loads a real sample
  localparam int WARM   = SYNC_STAGES + 1;
  localparam int CNT_W  = $clog2(WARM + 1);

  logic [CNT_W-1:0] warmCnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      warmCnt <= '0;
    end else if (warmCnt != CNT_W'(WARM)) begin
      warmCnt <= warmCnt + 1'b1;
    end
  end

  always_comb begin
    strb.primed   = (warmCnt == CNT_W'(WARM));
    strb.clrFlags = statusRead;
  end

  // R8: once primed, stays primed until the next reset
  assert_primed_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
    strb.primed |=> strb.primed);
endmodule

// File: rtl/mdm_status_dp.sv
module mdm_status_dp
  import mdm_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LINES-1:0] extLines,
  input  logic [CTRL_W-1:0]    ctrlBits,
  input  mdm_strobe_t          strb,
  output logic [7:0]           statusByte,
  output logic                 anyChange
);
  logic [NUM_LINES-1:0] syncQ [SYNC_STAGES];
  logic [NUM_LINES-1:0] loopLines;
  logic [NUM_LINES-1:0] curLvl;
  logic [NUM_LINES-1:0] refLvl;
  logic [NUM_LINES-1:0] edgeHit;
  logic [NUM_LINES-1:0] chgFlags;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < SYNC_STAGES; i++) syncQ[i] <= '0;
    end else begin
      syncQ[0] <= extLines;
      for (int i = 1; i < SYNC_STAGES; i++) syncQ[i] <= syncQ[i-1];
    end
  end

  always_comb begin
    loopLines[LN_CTS] = ctrlBits[CB_RTS];
    loopLines[LN_DSR] = ctrlBits[CB_DTR];
    loopLines[LN_RI]  = ctrlBits[CB_AUX];
    loopLines[LN_DCD] = ctrlBits[CB_GATE];
    curLvl = ctrlBits[CB_LOOP] ? loopLines : syncQ[SYNC_STAGES-1];
  end

  genvar g;
  generate
    for (g = 0; g < NUM_LINES; g++) begin : g_edge
      if (g == LN_RI) begin : g_trail
        assign edgeHit[g] = strb.primed & refLvl[g] & ~curLvl[g];
      end else begin : g_any
        assign edgeHit[g] = strb.primed & (refLvl[g] ^ curLvl[g]);
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      refLvl   <= '0;
      chgFlags <= '0;
    end else begin
      refLvl   <= curLvl;
      chgFlags <= (strb.clrFlags ? '0 : chgFlags) | edgeHit;
    end
  end

  assign statusByte = {curLvl, chgFlags};
  assign anyChange  = |chgFlags;

  // R8: no flag can exist before the reference levels are valid
  assert_no_early_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !strb.primed |-> (chgFlags == '0));

  // R4: without a read, flags never drop
  assert_flags_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !strb.clrFlags |=> ((chgFlags & $past(chgFlags)) == $past(chgFlags)));

  // R5: a read leaves only freshly detected changes
  assert_read_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
    strb.clrFlags |=> ((chgFlags & ~$past(edgeHit)) == '0));

  // R9: ring flag rises only after the ring level went from high to low
  assert_ri_trailing_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(chgFlags[LN_RI]) |-> ($past(refLvl[LN_RI]) && !$past(curLvl[LN_RI])));

  // R7: in loopback the levels track the control word
  assert_loop_levels_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ctrlBits[CB_LOOP] |-> (statusByte[7:4] ==
      {ctrlBits[CB_GATE], ctrlBits[CB_AUX], ctrlBits[CB_DTR], ctrlBits[CB_RTS]}));
endmodule

// File: rtl/mdm_status_top.sv
module mdm_status_top
  import mdm_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ctsIn,
  input  logic        dsrIn,
  input  logic        riIn,
  input  logic        dcdIn,
  input  logic [4:0]  ctrlBits,
  input  logic        msIntEn,
  input  logic        statusRead,
  output logic [7:0]  statusByte,
  output logic        msIrq,
  output logic        dtrOut,
  output logic        rtsOut,
  output logic        auxOut,
  output logic        gateOut
);
  mdm_strobe_t          strb;
  logic                 anyChange;
  logic [NUM_LINES-1:0] extLines;
  logic                 loopOn;

  assign extLines = {dcdIn, riIn, dsrIn, ctsIn};
  assign loopOn   = ctrlBits[CB_LOOP];

  mdm_status_ctl #(.SYNC_STAGES(SYNC_STAGES)) i_ctl (
    .clk        (clk),
    .rst_n      (rst_n),
    .statusRead (statusRead),
    .strb       (strb)
  );

  mdm_status_dp #(.SYNC_STAGES(SYNC_STAGES)) i_dp (
    .clk        (clk),
    .rst_n      (rst_n),
    .extLines   (extLines),
    .ctrlBits   (ctrlBits),
    .strb       (strb),
    .statusByte (statusByte),
    .anyChange  (anyChange)
  );

  assign msIrq   = msIntEn & anyChange;
  assign dtrOut  = ctrlBits[CB_DTR]  & ~loopOn;
  assign rtsOut  = ctrlBits[CB_RTS]  & ~loopOn;
  assign auxOut  = ctrlBits[CB_AUX]  & ~loopOn;
  assign gateOut = ctrlBits[CB_GATE] & ~loopOn;

  // R3: the request needs the enable
  assert_irq_gated_R3: assert property (@(posedge clk) disable iff (!rst_n)
    msIrq |-> msIntEn);

  // R3: an enabled pending flag always requests
  assert_irq_raised_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (msIntEn && statusByte[3:0] != 4'b0) |-> msIrq);

  // R6: loopback silences the outputs
  assert_loop_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    loopOn |-> ({dtrOut, rtsOut, auxOut, gateOut} == 4'b0));
endmodule

// File: tb/test_mdm_status_top.sv
`timescale 1ns/1ps
module test_mdm_status_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ctsIn = 1'b0, dsrIn = 1'b0, riIn = 1'b0, dcdIn = 1'b0;
  logic [4:0] ctrlBits = 5'b0;
  logic       msIntEn = 1'b0;
  logic       statusRead = 1'b0;
  logic [7:0] statusByte;
  logic       msIrq, dtrOut, rtsOut, auxOut, gateOut;

  int nRun = 0;
  int nFail = 0;

  always #2.5 clk = ~clk;

  mdm_status_top i_mdm_status_top (
    .clk(clk), .rst_n(rst_n),
    .ctsIn(ctsIn), .dsrIn(dsrIn), .riIn(riIn), .dcdIn(dcdIn),
    .ctrlBits(ctrlBits), .msIntEn(msIntEn), .statusRead(statusRead),
    .statusByte(statusByte), .msIrq(msIrq),
    .dtrOut(dtrOut), .rtsOut(rtsOut), .auxOut(auxOut), .gateOut(gateOut)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: got 0x%02h expected 0x%02h", req, act, exp);
    end
  endtask

  task automatic waitN(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic doRead();
    @(negedge clk) statusRead = 1'b1;
    @(negedge clk) statusRead = 1'b0;
  endtask

  task automatic t_reset();
    ctsIn = 1'b1; dcdIn = 1'b1; msIntEn = 1'b1;
    waitN(3);
    rst_n = 1'b1;
    #0.5 chk("R8 reset value", statusByte, 8'h00);
    waitN(6);
    chk("R8 no flag from first samples", statusByte, 8'h90);
    chk("R8 no irq after reset", {7'b0, msIrq}, 8'h00);
    msIntEn = 1'b0;
  endtask

  task automatic t_cts();
    @(negedge clk) ctsIn = 1'b0;
    waitN(2);
    chk("R2 level after two edges", statusByte, 8'h80);
    waitN(1);
    chk("R1 cts change flag", statusByte, 8'h81);
    chk("R3 irq masked", {7'b0, msIrq}, 8'h00);
    msIntEn = 1'b1;
    #0.5 chk("R3 irq enabled", {7'b0, msIrq}, 8'h01);
    doRead();
    chk("R5 read clears", statusByte, 8'h80);
    chk("R3 irq drops", {7'b0, msIrq}, 8'h00);
    msIntEn = 1'b0;
  endtask

  task automatic t_sticky();
    @(negedge clk) ctsIn = 1'b1;
    waitN(3);
    chk("R1 cts rising flag", statusByte, 8'h91);
    waitN(8);
    chk("R4 flag sticky", statusByte, 8'h91);
    doRead();
    chk("R5 read clears again", statusByte, 8'h90);
  endtask

  task automatic t_ri();
    @(negedge clk) riIn = 1'b1;
    waitN(5);
    chk("R9 ri rise no flag", statusByte, 8'hD0);
    @(negedge clk) riIn = 1'b0;
    waitN(3);
    chk("R9 ri trailing flag", statusByte, 8'h94);
    doRead();
    chk("R5 ri flag cleared", statusByte, 8'h90);
  endtask

  task automatic t_dsr_dcd();
    @(negedge clk) begin dsrIn = 1'b1; dcdIn = 1'b0; end
    waitN(3);
    chk("R1 dsr and dcd flags", statusByte, 8'h3A);
    doRead();
    chk("R5 cleared", statusByte, 8'h30);
  endtask

  task automatic t_outputs();
    @(negedge clk) ctrlBits = 5'b01111;
    #0.5 chk("R6 outputs follow", {4'b0, dtrOut, rtsOut, auxOut, gateOut}, 8'h0F);
    waitN(3);
    chk("R6 no effect on levels", statusByte, 8'h30);
    @(negedge clk) ctrlBits = 5'b00101;
    #0.5 chk("R6 outputs pattern", {4'b0, dtrOut, rtsOut, auxOut, gateOut}, 8'h0A);
  endtask

  task automatic t_loop();
    @(negedge clk) begin ctsIn = 1'b0; dsrIn = 1'b0; end
    waitN(3);
    doRead();
    chk("R5 baseline clear", statusByte, 8'h00);
    @(negedge clk) ctrlBits = 5'b10010;
    #0.5 chk("R6 loop outputs quiet", {4'b0, dtrOut, rtsOut, auxOut, gateOut}, 8'h00);
    waitN(1);
    chk("R7 cts follows rts", statusByte, 8'h11);
    doRead();
    chk("R5 clear in loop", statusByte, 8'h10);
    @(negedge clk) begin ctsIn = 1'b1; dcdIn = 1'b1; end
    waitN(4);
    chk("R7 external ignored", statusByte, 8'h10);
    // collision: read and new change in the same cycle
    @(negedge clk) begin ctrlBits = 5'b10011; statusRead = 1'b1; end
    @(negedge clk) statusRead = 1'b0;
    chk("R5 same-cycle change kept", statusByte, 8'h32);
    doRead();
    @(negedge clk) ctrlBits = 5'b11111;
    waitN(1);
    chk("R7 ri and dcd mapping", statusByte, 8'hF8);
    doRead();
    @(negedge clk) ctrlBits = 5'b10000;
    waitN(1);
    chk("R9 R1 all drop", statusByte, 8'h0F);
  endtask

  initial begin
    t_reset();
    t_cts();
    t_sticky();
    t_ri();
    t_dsr_dcd();
    t_outputs();
    t_loop();
    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    #50000;
    nRun++;
    nFail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end
endmodule